// File: doc/BRIEF.md
# Full-Duplex Serial Byte Link with Parity Check

This block moves bytes over a pair of asynchronous serial lines. The transmit half takes a byte from a write port, frames it, and shifts it out on the serial output. The receive half watches the serial input, rebuilds incoming frames, and presents each byte on a read port. Each half keeps one shift register and a one-byte holding register, so one byte can wait while another is on the wire.

Both halves advance on a single-cycle sample strobe supplied from outside. The strobe runs at eight times the bit rate. A frame is a low start bit, eight data bits sent least significant bit first, a parity bit, and a high stop bit. One control input picks even or odd parity for both directions. Two status bytes report the state of each half. Receive errors stay set until the status is read.

Top module: `serial_link_uart`

## Requirements
- R1: After reset `txd` is 1, `tx_status` is 0x10 and `rx_status` is 0x00.
- R2: A transmitted frame is a 0 start bit, then eight data bits least significant bit first, then the parity bit, then a 1 stop bit. Each bit lasts OVS sample strobes. The line is 1 whenever nothing is being sent.
- R3: With `parity_odd`=0 the data bits and the parity bit together hold an even number of ones. With `parity_odd`=1 they hold an odd number. This applies to what is sent and to what the receiver checks.
- R4: A write is accepted only while the transmit holding register is empty, shown as `tx_status` bit 4 (0x10). A write made while it is full is dropped. A byte waiting in the holding register starts right after the current stop bit, with no idle time between frames.
- R5: `tx_status` bit 5 (0x20, transmit complete) sets when a stop bit ends and no byte is waiting. An accepted write clears it.
- R6: A 0 on the line starts a receive only if it is still 0 at the fourth strobe after it was first seen (mid start bit). A shorter low pulse is ignored. `rx_status` bit 0 (0x01) is 1 while a frame is being received.
- R7: When the stop bit is sampled at its centre, `rx_data` takes the byte and `rx_status` bit 3 (0x08, receive full) sets. A pulse on `rd_en` clears receive full.
- R8: A parity mismatch sets `rx_status` bit 7 (0x80). A stop-bit sample of 0 sets `rx_status` bit 5 (0x20).
- R9: If a byte completes while receive full is still set (and not read in the same cycle), `rx_status` bit 6 (0x40) sets and the new byte replaces the old one.
- R10: A pulse on `stat_rd` clears `rx_status` bits 7..5 (mask 0xE0). If a new error arrives in the same cycle, the new error wins.
- R11: While `enable` is 0, `txd` is 1, any frame in progress and any waiting transmit byte are discarded, writes are ignored, and the receiver stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| tick | input | 1 | Sample strobe at OVS times the bit rate |
| parity_odd | input | 1 | 0 selects even parity, 1 selects odd parity |
| wr_en | input | 1 | Write strobe for a transmit byte |
| wr_data | input | DATA_W | Transmit byte |
| rd_en | input | 1 | Read strobe; clears receive full |
| stat_rd | input | 1 | Status read strobe; clears error flags |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| rx_data | output | DATA_W | Last received byte |
| tx_status | output | 8 | Bit 5 transmit complete, bit 4 holding empty |
| rx_status | output | 8 | Bit 7 parity, 6 overrun, 5 framing, 3 full, 0 active |

## Verification
The bench uses the default DATA_W=8 and OVS=8 and issues a strobe on every fourth clock, so one bit lasts 32 clocks. With bits that short, complete frames, back-to-back transmission from the holding register, and overruns all fit into a short run. The bench decodes the serial output at bit centres using only its own clock counts, so a wrong bit order, wrong parity sense or wrong bit length shows up without relying on the receive half. It drives the serial input with injected frames, including bad parity, a low stop bit, a glitch shorter than half a bit, and two frames with no read between them.

// File: rtl/serial_link_pkg.sv
package serial_link_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_BITS  = 2'd2
    } rx_state_e;

    // status bit positions (software decodes these)
    localparam int RXS_ACTIVE = 0;
    localparam int RXS_FULL   = 3;
    localparam int RXS_FRAME  = 5;
    localparam int RXS_OVR    = 6;
    localparam int RXS_PAR    = 7;
    localparam int TXS_EMPTY  = 4;
    localparam int TXS_DONE   = 5;
endpackage

// File: rtl/serial_link_tx.sv
module serial_link_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              parity_odd,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_empty,
    output logic              tx_done
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] SUB_LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] shift;
        logic [CNT_W-1:0]   sub;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W-1:0]  hold;
        logic               hold_vld;
        logic               done;
    } tx_regs_t;

    tx_regs_t tx_q, tx_d;
    logic     wr_ok;

    always_comb begin
        tx_d  = tx_q;
        wr_ok = wr_en && !tx_q.hold_vld;
        if (!enable) begin
            tx_d.busy     = 1'b0;
            tx_d.hold_vld = 1'b0;
            tx_d.done     = 1'b0;
            tx_d.sub      = '0;
            tx_d.idx      = '0;
        end else begin
            if (wr_ok) begin
                tx_d.hold     = wr_data;
                tx_d.hold_vld = 1'b1;
                tx_d.done     = 1'b0;
            end
            if (tick) begin
                if (!tx_q.busy || (tx_q.sub == SUB_LAST && tx_q.idx == IDX_LAST)) begin
                    if (tx_q.hold_vld) begin
                        tx_d.busy     = 1'b1;
                        tx_d.shift    = {1'b1, (^tx_q.hold) ^ parity_odd, tx_q.hold, 1'b0};
                        tx_d.sub      = '0;
                        tx_d.idx      = '0;
                        tx_d.hold_vld = 1'b0;
                    end else if (tx_q.busy) begin
                        tx_d.busy = 1'b0;
                        tx_d.done = !wr_ok;
                    end
                end else if (tx_q.sub == SUB_LAST) begin
                    tx_d.sub   = '0;
                    tx_d.idx   = tx_q.idx + IDX_W'(1);
                    tx_d.shift = {1'b1, tx_q.shift[FRAME_W-1:1]};
                end else begin
                    tx_d.sub = tx_q.sub + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign txd      = tx_q.busy ? tx_q.shift[0] : 1'b1;
    assign tx_empty = !tx_q.hold_vld;
    assign tx_done  = tx_q.done;
endmodule

// File: rtl/serial_link_rx.sv
module serial_link_rx
    import serial_link_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              parity_odd,
    input  logic              rxd,
    input  logic              rd_en,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_active,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err
);
    localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int IDX_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] SUB_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] SUB_MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_STOP = IDX_W'(DATA_W + 1);

    typedef struct packed {
        logic [1:0]        sync;
        rx_state_e         state;
        logic [CNT_W-1:0]  sub;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W:0]   shift;
        logic [DATA_W-1:0] data;
        logic              full;
        logic              perr;
        logic              ferr;
        logic              ovr;
    } rx_regs_t;

    rx_regs_t rx_q, rx_d;
    logic     line;

    always_comb begin
        rx_d      = rx_q;
        line      = rx_q.sync[1];
        rx_d.sync = {rx_q.sync[0], rxd};
        if (rd_en) rx_d.full = 1'b0;
        if (stat_rd) begin
            rx_d.perr = 1'b0;
            rx_d.ferr = 1'b0;
            rx_d.ovr  = 1'b0;
        end
        if (!enable) begin
            rx_d.state = RX_IDLE;
        end else if (tick) begin
            case (rx_q.state)
                RX_IDLE: begin
                    if (!line) begin
                        rx_d.state = RX_START;
                        rx_d.sub   = '0;
                    end
                end
                RX_START: begin
                    if (rx_q.sub == SUB_MID) begin
                        rx_d.state = line ? RX_IDLE : RX_BITS;
                        rx_d.sub   = '0;
                        rx_d.idx   = '0;
                    end else begin
                        rx_d.sub = rx_q.sub + CNT_W'(1);
                    end
                end
                RX_BITS: begin
                    if (rx_q.sub == SUB_LAST) begin
                        rx_d.sub = '0;
                        if (rx_q.idx == IDX_STOP) begin
                            rx_d.state = RX_IDLE;
                            rx_d.data  = rx_q.shift[DATA_W-1:0];
                            rx_d.full  = 1'b1;
                            if (rx_q.full && !rd_en) rx_d.ovr = 1'b1;
                            if (!line) rx_d.ferr = 1'b1;
                            if (((^rx_q.shift[DATA_W-1:0]) ^ parity_odd) != rx_q.shift[DATA_W])
                                rx_d.perr = 1'b1;
                        end else begin
                            rx_d.shift = {line, rx_q.shift[DATA_W:1]};
                            rx_d.idx   = rx_q.idx + IDX_W'(1);
                        end
                    end else begin
                        rx_d.sub = rx_q.sub + CNT_W'(1);
                    end
                end
                default: rx_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q      <= '0;
            rx_q.sync <= 2'b11;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_data   = rx_q.data;
    assign rx_full   = rx_q.full;
    assign rx_active = (rx_q.state != RX_IDLE);
    assign par_err   = rx_q.perr;
    assign frm_err   = rx_q.ferr;
    assign ovr_err   = rx_q.ovr;
endmodule

// File: rtl/serial_link_uart.sv
module serial_link_uart
    import serial_link_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              parity_odd,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              stat_rd,
    input  logic              rxd,
    output logic              txd,
    output logic [DATA_W-1:0] rx_data,
    output logic [7:0]        tx_status,
    output logic [7:0]        rx_status
);
    logic tx_empty, tx_done;
    logic rx_full, rx_active, par_err, frm_err, ovr_err;

    serial_link_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .parity_odd(parity_odd), .wr_en(wr_en), .wr_data(wr_data),
        .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done)
    );

    serial_link_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .parity_odd(parity_odd), .rxd(rxd), .rd_en(rd_en), .stat_rd(stat_rd),
        .rx_data(rx_data), .rx_full(rx_full), .rx_active(rx_active),
        .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
    );

    always_comb begin
        tx_status            = '0;
        tx_status[TXS_EMPTY] = tx_empty;
        tx_status[TXS_DONE]  = tx_done;
        rx_status             = '0;
        rx_status[RXS_ACTIVE] = rx_active;
        rx_status[RXS_FULL]   = rx_full;
        rx_status[RXS_FRAME]  = frm_err;
        rx_status[RXS_OVR]    = ovr_err;
        rx_status[RXS_PAR]    = par_err;
    end
endmodule

// File: rtl/serial_link_uart_chk.sv
module serial_link_uart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       wr_en,
    input logic       stat_rd,
    input logic       txd,
    input logic [7:0] tx_status,
    input logic [7:0] rx_status
);
    // R11: disabled block drives an idle line
    p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> txd);

    // R5: transmit complete only with an idle line
    p_done_idle_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_status[5] |-> txd);

    // R4: an accepted write fills the holding register
    p_write_fills_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr_en && tx_status[4]) |=> !tx_status[4]);

    // R7: receive full rises only at the end of an active frame
    p_full_after_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_status[3]) |-> $past(rx_status[0]));

    // R9: overrun appears together with receive full
    p_ovr_with_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_status[6]) |-> rx_status[3]);

    // R10: status read with no frame ending clears the error flags
    p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !rx_status[0]) |=> (rx_status[7:5] == 3'b000));
endmodule

bind serial_link_uart serial_link_uart_chk u_chk (.*);

// File: tb/serial_link_uart_tb.sv
module serial_link_uart_tb;
    localparam int DW     = 8;
    localparam int OVS    = 8;
    localparam int BITCLK = OVS * 4;

    logic          clk = 1'b0, rst_n = 1'b0, enable = 1'b0, tick = 1'b0;
    logic          parity_odd = 1'b0, wr_en = 1'b0, rd_en = 1'b0, stat_rd = 1'b0;
    logic          rxd = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          txd;
    logic [DW-1:0] rx_data;
    logic [7:0]    tx_status, rx_status;
    logic [1:0]    tdiv = 2'd0;

    int n_tests = 0, n_fail = 0, frames_seen = 0;
    logic [DW:0] exp_q[$];

    serial_link_uart #(.DATA_W(DW), .OVS(OVS)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .parity_odd(parity_odd), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .stat_rd(stat_rd), .rxd(rxd), .txd(txd),
        .rx_data(rx_data), .tx_status(tx_status), .rx_status(rx_status)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd3);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // driver: pushes the expected frame when the write should be accepted
    task automatic write_tx(input logic [DW-1:0] d, input bit accept);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        if (accept) exp_q.push_back({(^d) ^ parity_odd, d});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tx_done();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (tx_status[5]) break;
        end
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse_stat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic send_rx(input logic [DW-1:0] d, input bit bad_par, input bit bad_stop);
        logic [DW+2:0] f;
        f = {!bad_stop, (^d) ^ parity_odd ^ bad_par, d, 1'b0};
        for (int i = 0; i < DW + 3; i++) begin
            @(negedge clk); rxd = f[i];
            repeat (BITCLK - 1) @(negedge clk);
        end
        @(negedge clk); rxd = 1'b1;
        repeat (BITCLK) @(negedge clk);
    endtask

    // monitor: decodes the serial output at bit centres and pops the scoreboard
    initial begin
        logic          prev;
        logic [DW+2:0] f;
        logic [DW:0]   e;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !txd) begin
                repeat (BITCLK / 2) @(negedge clk);
                f[0] = txd;
                for (int i = 1; i < DW + 3; i++) begin
                    repeat (BITCLK) @(negedge clk);
                    f[i] = txd;
                end
                frames_seen++;
                if (exp_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R4: unexpected frame actual %0h expected none", f);
                end else begin
                    e = exp_q.pop_front();
                    chk("R2 start bit", f[0], 0);
                    chk("R2 data bits", f[DW:1], e[DW-1:0]);
                    chk("R3 parity bit", f[DW+1], e[DW]);
                    chk("R2 stop bit", f[DW+2], 1);
                end
            end
            prev = txd;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        int seen;
        repeat (5) @(negedge clk);
        chk("R1 txd", txd, 1);
        chk("R1 tx_status", tx_status, 8'h10);
        chk("R1 rx_status", rx_status, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        enable = 1'b1;
        repeat (8) @(negedge clk);
        chk("R1 idle line", txd, 1);

        // even parity transmit
        write_tx(8'hA5, 1'b1);
        wait_tx_done();
        chk("R5 complete", tx_status, 8'h30);

        // holding register: two accepted, third dropped, frames back to back
        write_tx(8'h3C, 1'b1);
        repeat (6) @(negedge clk);
        chk("R5 cleared by write", tx_status, 8'h10);
        write_tx(8'hF0, 1'b1);
        chk("R4 holding full", tx_status, 8'h00);
        write_tx(8'h81, 1'b0);
        wait_tx_done();
        repeat (4) @(negedge clk);
        chk("R4 queue drained", exp_q.size(), 0);
        chk("R4 frame count", frames_seen, 3);

        // odd parity transmit
        parity_odd = 1'b1;
        write_tx(8'h07, 1'b1);
        wait_tx_done();
        write_tx(8'hE8, 1'b1);
        wait_tx_done();
        chk("R3 odd frames", frames_seen, 5);

        // disabled block
        enable = 1'b0;
        seen = frames_seen;
        write_tx(8'h55, 1'b0);
        chk("R11 write ignored", tx_status, 8'h10);
        send_rx(8'h66, 1'b0, 1'b0);
        chk("R11 txd idle", txd, 1);
        chk("R11 rx idle", rx_status, 8'h00);
        chk("R11 no frame", frames_seen, seen);
        enable = 1'b1;
        parity_odd = 1'b0;
        repeat (8) @(negedge clk);

        // receive a good byte, watch the active flag mid-frame
        fork
            send_rx(8'h5A, 1'b0, 1'b0);
            begin
                repeat (3 * BITCLK) @(negedge clk);
                chk("R6 active", rx_status[0], 1);
            end
        join
        chk("R7 full", rx_status, 8'h08);
        chk("R7 data", rx_data, 8'h5A);
        pulse_rd();
        chk("R7 read clears", rx_status, 8'h00);

        // parity error, then status read clears it
        send_rx(8'h33, 1'b1, 1'b0);
        chk("R8 parity error", rx_status, 8'h88);
        pulse_stat();
        chk("R10 clear errors", rx_status, 8'h08);
        pulse_rd();

        // framing error
        send_rx(8'hC4, 1'b0, 1'b1);
        chk("R8 framing error", rx_status, 8'h28);
        chk("R8 data", rx_data, 8'hC4);
        pulse_rd();
        pulse_stat();
        chk("R10 clear framing", rx_status, 8'h00);

        // overrun
        send_rx(8'h11, 1'b0, 1'b0);
        send_rx(8'h22, 1'b0, 1'b0);
        chk("R9 overrun", rx_status, 8'h48);
        chk("R9 newest data", rx_data, 8'h22);
        pulse_rd();
        pulse_stat();

        // odd parity receive
        parity_odd = 1'b1;
        send_rx(8'h96, 1'b0, 1'b0);
        chk("R3 odd receive", rx_status, 8'h08);
        chk("R3 odd data", rx_data, 8'h96);
        pulse_rd();

        // glitch shorter than half a bit
        @(negedge clk); rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        chk("R6 glitch ignored", rx_status, 8'h00);

        summary();
    end
endmodule